// File: doc/BRIEF.md
# Stereo Feature Consistency Checker

This block takes three per-pixel streams that describe the same scanline of a rectified stereo pair. The first is a corner bit for the left image and the second is a corner bit for the right image. The third is a disparity value that comes from a separate matching stage, so it arrives with a different latency. The block realigns the disparity stream with the corner streams by delaying it a fixed number of valid pixels. A left-image corner survives only if the right-image pixel at the same column minus the disparity is also a corner.

The result is one value per pixel. It carries the disparity where a feature is confirmed and zero everywhere else. Valid, line-start and frame-start flags travel with it, so a downstream consumer can read feature positions and depths straight from a single stream. The right-image history is a tapped shift register, and the live disparity selects one of its taps, so each left pixel is decided in the cycle it arrives.

Top module: `stereo_feat_confirm`

## Requirements
- R1: While reset is asserted, and after it until the first valid pixel has passed, outValid, outLineStart and outFrameStart are 0 and outDisp is 0.
- R2: The disparity applied to a pixel is the inDisp value presented DISP_DELAY valid pixels earlier. During the first DISP_DELAY valid pixels after reset, the applied disparity is 0.
- R3: When the left corner bit is 1 and the right corner bit at column (column − d) of the same line is 1, outDisp equals d. Here d is the applied disparity after the saturation of R6.
- R4: outDisp is 0 when the left corner bit of the pixel is 0, or when the right corner bit at the displaced column is 0.
- R5: When d is greater than the pixel's column, the displaced position falls before the line start and the feature is rejected, so outDisp is 0.
- R6: An applied disparity above MAX_DISP−1 is treated as MAX_DISP−1, both for tap selection and for the value placed on outDisp.
- R7: Outputs appear exactly one clock after the input pixel. outValid, outLineStart and outFrameStart repeat the pixel's inValid, inValid&inLineStart and inValid&inFrameStart.
- R8: A cycle with inValid=0 produces outValid=0 and outDisp=0. It advances neither the column, the disparity delay line nor the right-corner history, whatever the other inputs carry.
- R9: A valid pixel with inLineStart=1 is column 0. Each further valid pixel is one column higher, saturating at LINE_MAX−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Pixel present on the inputs this cycle |
| inLineStart | input | 1 | Pixel is the first of a scanline |
| inFrameStart | input | 1 | Pixel is the first of a frame |
| inLeftCorner | input | 1 | Left-image corner bit |
| inRightCorner | input | 1 | Right-image corner bit |
| inDisp | input | DISP_W | Disparity stream, DISP_DELAY pixels ahead of the corners |
| outValid | output | 1 | Output pixel present |
| outLineStart | output | 1 | Output pixel starts a scanline |
| outFrameStart | output | 1 | Output pixel starts a frame |
| outDisp | output | DISP_W | Confirmed disparity, or 0 |

## Verification
The bench builds the block with MAX_DISP=8, DISP_W=5, DISP_DELAY=3 and LINE_MAX=64, over scanlines of 16 pixels. With these values, a disparity of 7 against columns 0 to 7 exercises the line-start rejection on every tap. A 5-bit input of 20 lies above the 8-tap window, so saturation can be observed at the ports. A three-pixel delay spans line boundaries and the zero-filled start after reset. Idle cycles inserted inside a line, with active-looking inputs, show that the history, the column and the delay line hold still.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Per-pixel strobes passed from control to datapath
  typedef struct packed {
    logic advance;     // a valid pixel is present
    logic lineStart;   // valid pixel opens a line
    logic frameStart;  // valid pixel opens a frame
  } sfc_strobe_t;

endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int LINE_MAX = 2048,
  localparam int COL_W = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLineStart,
  input  logic             inFrameStart,
  output sfc_strobe_t      strobe,
  output logic [COL_W-1:0] col
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_MAX - 1);

  logic [COL_W-1:0] colQ;

  always_comb begin
    col               = inLineStart ? '0 : colQ;
    strobe.advance    = inValid;
    strobe.lineStart  = inValid & inLineStart;
    strobe.frameStart = inValid & inFrameStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ <= '0;
    end else if (inValid) begin
      colQ <= (col == COL_LAST) ? col : col + 1'b1;
    end
  end

  // R9: a line-start pixel is column 0, so the next one is column 1
  a_r9_line_restart: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLineStart) |=> (colQ == COL_W'(1)));

  // R8: idle cycles leave the column untouched
  a_r8_col_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(colQ));

endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DISP_W     = 8,
  parameter int MAX_DISP   = 64,
  parameter int DISP_DELAY = 4,
  parameter int LINE_MAX   = 2048,
  localparam int SEL_W = $clog2(MAX_DISP),
  localparam int COL_W = $clog2(LINE_MAX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfc_strobe_t       strobe,
  input  logic [COL_W-1:0]  col,
  input  logic              inLeft,
  input  logic              inRight,
  input  logic [DISP_W-1:0] inDisp,
  output logic              outValid,
  output logic              outLineStart,
  output logic              outFrameStart,
  output logic [DISP_W-1:0] outDisp
);

  localparam logic [DISP_W-1:0] DISP_TOP = DISP_W'(MAX_DISP - 1);

  logic [DISP_W-1:0]   dispAligned;
  logic [MAX_DISP-1:1] histQ;      // histQ[k]: right corner k columns back
  logic [MAX_DISP-1:0] rightWin;   // rightWin[0]: live right corner
  logic [SEL_W-1:0]    dSat;
  logic                inRange;
  logic                confirmed;

  // Disparity alignment: a delay line counted in valid pixels
  generate
    if (DISP_DELAY == 0) begin : g_nodelay
      assign dispAligned = inDisp;
    end else begin : g_delay
      logic [DISP_W-1:0] dlyQ [DISP_DELAY];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < DISP_DELAY; i++) dlyQ[i] <= '0;
        end else if (strobe.advance) begin
          dlyQ[0] <= inDisp;
          for (int i = 1; i < DISP_DELAY; i++) dlyQ[i] <= dlyQ[i-1];
        end
      end
      assign dispAligned = dlyQ[DISP_DELAY-1];
    end
  endgenerate

  // Right-corner history, one tap per disparity value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (strobe.advance) begin
      histQ <= {histQ[MAX_DISP-2:1], inRight};
    end
  end

  always_comb begin
    rightWin  = {histQ, inRight};
    dSat      = (dispAligned > DISP_TOP) ? SEL_W'(MAX_DISP - 1)
                                         : dispAligned[SEL_W-1:0];
    inRange   = (32'(dSat) <= 32'(col));
    confirmed = strobe.advance & inLeft & inRange & rightWin[dSat];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outLineStart  <= 1'b0;
      outFrameStart <= 1'b0;
      outDisp       <= '0;
    end else begin
      outValid      <= strobe.advance;
      outLineStart  <= strobe.lineStart;
      outFrameStart <= strobe.frameStart;
      outDisp       <= confirmed ? DISP_W'(dSat) : '0;
    end
  end

  // R7: each valid pixel yields an output one clock later
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> outValid);

  // R8: idle cycles produce an empty output
  a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> (!outValid && outDisp == '0));

  // R5: a confirmed disparity never reaches past the line start
  a_r5_col_bound: assert property (@(posedge clk) disable iff (!rstN)
    (outDisp != '0) |-> (32'(outDisp) <= 32'($past(col))));

  // R6: output never exceeds the top tap
  a_r6_sat_bound: assert property (@(posedge clk) disable iff (!rstN)
    outDisp <= DISP_TOP);

  // R3: a non-zero result needs a left corner on that pixel
  a_r3_needs_left: assert property (@(posedge clk) disable iff (!rstN)
    (outDisp != '0) |-> $past(inLeft));

endmodule

// File: rtl/stereo_feat_confirm.sv
module stereo_feat_confirm
  import sfc_pkg::*;
#(
  parameter int DISP_W     = 8,
  parameter int MAX_DISP   = 64,
  parameter int DISP_DELAY = 4,
  parameter int LINE_MAX   = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLineStart,
  input  logic              inFrameStart,
  input  logic              inLeftCorner,
  input  logic              inRightCorner,
  input  logic [DISP_W-1:0] inDisp,
  output logic              outValid,
  output logic              outLineStart,
  output logic              outFrameStart,
  output logic [DISP_W-1:0] outDisp
);

  localparam int COL_W = $clog2(LINE_MAX);

  sfc_strobe_t      strobe;
  logic [COL_W-1:0] col;

  sfc_ctrl #(
    .LINE_MAX(LINE_MAX)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inLineStart (inLineStart),
    .inFrameStart(inFrameStart),
    .strobe      (strobe),
    .col         (col)
  );

  sfc_datapath #(
    .DISP_W    (DISP_W),
    .MAX_DISP  (MAX_DISP),
    .DISP_DELAY(DISP_DELAY),
    .LINE_MAX  (LINE_MAX)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .col          (col),
    .inLeft       (inLeftCorner),
    .inRight      (inRightCorner),
    .inDisp       (inDisp),
    .outValid     (outValid),
    .outLineStart (outLineStart),
    .outFrameStart(outFrameStart),
    .outDisp      (outDisp)
  );

endmodule

// File: tb/test_stereo_feat_confirm.sv
module test_stereo_feat_confirm;

  localparam int DW    = 5;
  localparam int MD    = 8;
  localparam int DLY   = 3;
  localparam int LMAX  = 64;
  localparam int WIDTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLineStart = 1'b0, inFrameStart = 1'b0;
  logic inLeftCorner = 1'b0, inRightCorner = 1'b0;
  logic [DW-1:0] inDisp = '0;
  logic outValid, outLineStart, outFrameStart;
  logic [DW-1:0] outDisp;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stereo_feat_confirm #(
    .DISP_W(DW), .MAX_DISP(MD), .DISP_DELAY(DLY), .LINE_MAX(LMAX)
  ) i_stereo_feat_confirm (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLineStart(inLineStart),
    .inFrameStart(inFrameStart), .inLeftCorner(inLeftCorner),
    .inRightCorner(inRightCorner), .inDisp(inDisp), .outValid(outValid),
    .outLineStart(outLineStart), .outFrameStart(outFrameStart),
    .outDisp(outDisp)
  );

  // Line kinds: 0 mixed, 1 line-start boundary, 2 saturation,
  // 3 mixed with gaps, 4 mixed with frame start, 5 no right corners
  function automatic int kindOf(int m);
    return m / WIDTH;
  endfunction

  function automatic int hashOf(int m);
    return ((m * 73 + 19) * (m + 5)) ^ (m >> 2);
  endfunction

  function automatic int dAlign(int m);
    int x;
    x = m % WIDTH;
    if (m < DLY) return 0;  // R2: zero-filled start
    case (kindOf(m))
      1: return (x < 8) ? 7 : (x % 8);
      2: return 20;
      default: return (hashOf(m) >> 3) % 8;
    endcase
  endfunction

  function automatic bit leftAt(int m);
    case (kindOf(m))
      1, 2, 5: return 1'b1;
      default: return ((hashOf(m) >> 1) % 4) != 0;
    endcase
  endfunction

  function automatic bit rightAt(int m);
    case (kindOf(m))
      1: return 1'b1;
      2: return (m % 3) == 0;
      5: return 1'b0;
      default: return ((m * 11 + 3) % 5) < 3;
    endcase
  endfunction

  function automatic int expOut(int m);
    int ds, col;
    ds  = (dAlign(m) > MD - 1) ? MD - 1 : dAlign(m);   // R6
    col = m % WIDTH;
    if (leftAt(m) && ds <= col && rightAt(m - ds)) return ds;
    return 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stepPixel(int m, bit fs);
    int x, e;
    x = m % WIDTH;
    @(negedge clk);
    inValid       = 1'b1;
    inLineStart   = (x == 0);
    inFrameStart  = fs && (x == 0);
    inLeftCorner  = leftAt(m);
    inRightCorner = rightAt(m);
    inDisp        = DW'(dAlign(m + DLY));
    @(posedge clk);
    #1;
    e = expOut(m);
    // R7: flags one clock later
    check(outValid && outLineStart == (x == 0) &&
          outFrameStart == (fs && x == 0), "R7",
          {outValid, outLineStart, outFrameStart},
          {1'b1, x == 0, fs && x == 0});
    // R3 R4 R5 R6 R2 R9: value follows the model
    check(int'(outDisp) == e, "R3/R4/R5 (R2 R6 R9)", outDisp, e);
  endtask

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0; inLineStart = 1'b1; inFrameStart = 1'b1;
    inLeftCorner = 1'b1; inRightCorner = 1'b1; inDisp = DW'(3);
    @(posedge clk);
    #1;
    check(!outValid && outDisp == '0, "R8", {outValid, outDisp}, 0);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1;
    check(!outValid && !outLineStart && !outFrameStart && outDisp == '0,
          "R1", {outValid, outLineStart, outFrameStart, outDisp}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(!outValid && outDisp == '0, "R1", {outValid, outDisp}, 0);
  endtask

  task automatic runLine(int line, bit fs, bit gaps);
    for (int x = 0; x < WIDTH; x++) begin
      stepPixel(line * WIDTH + x, fs);
      if (gaps && x == 5) begin
        for (int g = 0; g < 3; g++) idleCycle();  // R8
      end
    end
  endtask

  task automatic testMixed();        runLine(0, 1'b1, 1'b0); endtask
  task automatic testBoundary();     runLine(1, 1'b0, 1'b0); endtask  // R5 R9
  task automatic testSaturation();   runLine(2, 1'b0, 1'b0); endtask  // R6
  task automatic testGaps();         runLine(3, 1'b0, 1'b1); endtask  // R8
  task automatic testFrame();        runLine(4, 1'b1, 1'b0); endtask  // R7
  task automatic testNoRight();      runLine(5, 1'b0, 1'b0); endtask  // R4

  initial begin
    testReset();
    testMixed();
    testBoundary();
    testSaturation();
    testGaps();
    testFrame();
    testNoRight();
    idleCycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule